// File: doc/BRIEF.md
# Object Memory Page Copy Engine

This block moves one full 256-byte page of processor memory into the 256-entry sprite attribute store. The processor starts it with a single register write, and the value written selects the source page. While the copy runs the engine owns the processor's memory bus and holds the processor in a stall. It reads one byte of the page, then writes that byte into the attribute store, and repeats this for every byte. The first destination address is the current object address, which the engine samples at the trigger. Destination addresses wrap within the store, so a copy that starts in the middle of the store fills the end first and then the beginning.

This replaces 256 separate data-port writes from software. A short alignment delay comes before the first bus read. It lasts one cycle, or two when the trigger falls on an odd processor cycle. Because of this, every transfer reads on even cycles, and the stall length depends only on the parity of the trigger cycle. When the last byte has been written, a one-cycle done pulse marks the end of the transfer.

Top module: `page_dma_engine`

## Requirements
- R1: A transfer starts only on a register write to address 0x4014 while the engine is idle. Writes to any other address leave stall and the bus read strobe low.
- R2: For a trigger carrying page value P, the source reads go to addresses {P, k} for k = 0 up to 255, in ascending order, with exactly one read per byte.
- R3: The k-th byte is written to object address (S + k) mod 256, where S is the object address input sampled in the trigger cycle. Addresses wrap from 255 back to 0.
- R4: Each read cycle is followed immediately by one write cycle. The byte written is the value on the read-data input during the preceding read cycle. Read and write never occur in the same cycle.
- R5: The trigger cycle is numbered from reset, and the first cycle after reset release is even. If the trigger cycle T is even, the first read occurs in cycle T+2. If T is odd, it occurs in cycle T+3.
- R6: Stall is high from the cycle after the trigger through the last write cycle. That is 513 cycles for an even trigger and 514 cycles for an odd trigger.
- R7: Done is high for exactly one cycle, the cycle right after the last write. Stall is low in that cycle.
- R8: A trigger write that arrives while a transfer is active is ignored. The running transfer keeps its source page, its destination sequence and its length.
- R9: After reset, stall, done, the read strobe and the write strobe are all low.
- R10: Each accepted trigger produces exactly 256 object writes and 256 source reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Processor register write strobe |
| regAddr | input | 16 | Processor register write address |
| regWrData | input | 8 | Processor register write data (page number) |
| objAddrIn | input | 8 | Current object address, used as the first destination |
| memRdEn | output | 1 | Bus-master read strobe |
| memRdAddr | output | 16 | Bus-master read address |
| memRdData | input | 8 | Read data, valid in the cycle the read strobe is high |
| objWrEn | output | 1 | Object memory write strobe |
| objWrAddr | output | 8 | Object memory write address |
| objWrData | output | 8 | Object memory write data |
| stall | output | 1 | Holds the processor while the transfer runs |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Some rules hold on every cycle, and the bound checker tests those continuously. These are the strict read-then-write alternation, the one-step progression of source and destination addresses, the stall length of 513 or 514 cycles, the single-cycle done pulse that follows a write, and a start only ever coming from a trigger decode. Other behaviour needs a known stimulus, so only the directed scenarios can show it. These are the match between written bytes and the chosen page, the wrap of the destination at a chosen start address, the alignment offset measured against the parity of the trigger cycle, and the rejection of decoys and of a second trigger issued mid-transfer.

// File: rtl/page_dma_pkg.sv
package page_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_READ,
    ST_WRITE
  } dmaState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic start;    // load page, zero source index, sample destination base
    logic capture;  // latch the byte returned by the bus read
    logic advance;  // step source index and destination address
  } dmaStrobe_t;

endpackage

// File: rtl/page_dma_ctrl.sv
module page_dma_ctrl
  import page_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TRIGGER_ADDR = 16'h4014
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              lastByte,
  output dmaStrobe_t        strobe,
  output logic              stall,
  output logic              done,
  output logic              rdEn,
  output logic              wrEn
);

  dmaState_t state, stateNext;
  logic oddCyc;       // parity of the current cycle, counted from reset
  logic extraAlign;   // one more alignment cycle is still owed
  logic trigAccept;

  assign trigAccept = regWrEn && (regAddr == TRIGGER_ADDR) && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) oddCyc <= 1'b0;
    else       oddCyc <= ~oddCyc;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (trigAccept) stateNext = ST_ALIGN;
      ST_ALIGN: if (!extraAlign) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = lastByte ? ST_IDLE : ST_READ;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      extraAlign <= 1'b0;
      done       <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_WRITE) && lastByte;
      if (trigAccept)              extraAlign <= oddCyc;
      else if (state == ST_ALIGN)  extraAlign <= 1'b0;
    end
  end

  always_comb begin
    strobe.start   = trigAccept;
    strobe.capture = (state == ST_READ);
    strobe.advance = (state == ST_WRITE);
  end

  assign stall = (state != ST_IDLE);
  assign rdEn  = (state == ST_READ);
  assign wrEn  = (state == ST_WRITE);

endmodule

// File: rtl/page_dma_datapath.sv
module page_dma_datapath
  import page_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [IDX_W-1:0]  objAddrIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [IDX_W-1:0]  objWrAddr,
  output logic [DATA_W-1:0] objWrData,
  output logic              lastByte
);

  logic [PAGE_W-1:0] pageReg;
  logic [IDX_W-1:0]  srcIdx;
  logic [IDX_W-1:0]  dstAddr;
  logic [DATA_W-1:0] byteHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg  <= '0;
      srcIdx   <= '0;
      dstAddr  <= '0;
      byteHold <= '0;
    end else begin
      if (strobe.start) begin
        pageReg <= regWrData[PAGE_W-1:0];
        srcIdx  <= '0;
        dstAddr <= objAddrIn;
      end else if (strobe.advance) begin
        srcIdx  <= srcIdx + 1'b1;
        dstAddr <= dstAddr + 1'b1;   // wraps modulo the store size
      end
      if (strobe.capture) byteHold <= memRdData;
    end
  end

  assign memRdAddr = {pageReg, srcIdx};
  assign objWrAddr = dstAddr;
  assign objWrData = byteHold;
  assign lastByte  = &srcIdx;

endmodule

// File: rtl/page_dma_engine.sv
module page_dma_engine
  import page_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter logic [ADDR_W-1:0] TRIGGER_ADDR = 16'h4014
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [IDX_W-1:0]  objAddrIn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              objWrEn,
  output logic [IDX_W-1:0]  objWrAddr,
  output logic [DATA_W-1:0] objWrData,
  output logic              stall,
  output logic              done
);

  dmaStrobe_t strobe;
  logic lastByte;

  page_dma_ctrl #(
    .ADDR_W(ADDR_W),
    .TRIGGER_ADDR(TRIGGER_ADDR)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .lastByte(lastByte),
    .strobe(strobe),
    .stall(stall),
    .done(done),
    .rdEn(memRdEn),
    .wrEn(objWrEn)
  );

  page_dma_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .IDX_W(IDX_W)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .regWrData(regWrData),
    .objAddrIn(objAddrIn),
    .memRdData(memRdData),
    .memRdAddr(memRdAddr),
    .objWrAddr(objWrAddr),
    .objWrData(objWrData),
    .lastByte(lastByte)
  );

endmodule

// File: rtl/page_dma_engine_checker.sv
module page_dma_engine_checker #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter logic [ADDR_W-1:0] TRIGGER_ADDR = 16'h4014
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memRdAddr,
  input logic              objWrEn,
  input logic [IDX_W-1:0]  objWrAddr,
  input logic              stall,
  input logic              done
);

  localparam int XFER_CYC = 2 * (2 ** IDX_W);
  localparam int SHORT_RUN = XFER_CYC + 1;
  localparam int LONG_RUN  = XFER_CYC + 2;

  logic [IDX_W+2:0] stallRun;

  always_ff @(posedge clk) begin
    if (!rstN)      stallRun <= '0;
    else if (stall) stallRun <= stallRun + 1'b1;
    else            stallRun <= '0;
  end

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> objWrEn);  // R4
  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && objWrEn));  // R4
  AST_BUS_UNDER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || objWrEn) |-> stall);  // R6
  AST_STALL_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stall) |-> (stallRun == SHORT_RUN || stallRun == LONG_RUN));  // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R7
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!stall && $past(objWrEn)));  // R7
  AST_SRC_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memRdEn, 2)) |-> (memRdAddr == $past(memRdAddr, 2) + 1'b1));  // R2
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (objWrEn && $past(objWrEn, 2)) |-> (objWrAddr == IDX_W'($past(objWrAddr, 2) + 1'b1)));  // R3
  AST_START_FROM_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(regWrEn && regAddr == TRIGGER_ADDR));  // R1

endmodule

bind page_dma_engine page_dma_engine_checker #(
  .ADDR_W(ADDR_W),
  .IDX_W(IDX_W),
  .TRIGGER_ADDR(TRIGGER_ADDR)
) chk (.*);

// File: tb/page_dma_engine_test.sv
module page_dma_engine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  objAddrIn = '0;
  logic        memRdEn;
  logic [15:0] memRdAddr;
  logic [7:0]  memRdData;
  logic        objWrEn;
  logic [7:0]  objWrAddr;
  logic [7:0]  objWrData;
  logic        stall;
  logic        done;

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [7:0] memVal(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd29) ^ 8'hA5;
  endfunction

  assign memRdData = memVal(memRdAddr);

  page_dma_engine uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .objAddrIn(objAddrIn), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .objWrEn(objWrEn),
    .objWrAddr(objWrAddr), .objWrData(objWrData), .stall(stall), .done(done)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int wdog = 0;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  // Monitor state
  logic [7:0]  expPage, expStart;
  logic [7:0]  objMem [256];
  logic [15:0] lastRdAddr = '0;
  logic        prevRd = 1'b0;
  int stallCnt, rdIdx, wrIdx, doneCnt, firstRdCyc, lastWrCyc, doneCyc;
  int srcErr, dstErr, altErr, dataErr, doneStallErr;

  task automatic clearLog();
    stallCnt = 0; rdIdx = 0; wrIdx = 0; doneCnt = 0;
    firstRdCyc = -1; lastWrCyc = -1; doneCyc = -1;
    srcErr = 0; dstErr = 0; altErr = 0; dataErr = 0; doneStallErr = 0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (stall) stallCnt++;
      if (memRdEn) begin
        if (firstRdCyc < 0) firstRdCyc = cyc;
        if (memRdAddr != {expPage, 8'(rdIdx)}) srcErr++;
        lastRdAddr = memRdAddr;
        rdIdx++;
      end
      if (objWrEn) begin
        if (!prevRd) altErr++;
        if (objWrAddr != 8'(expStart + 8'(wrIdx))) dstErr++;
        if (objWrData != memVal(lastRdAddr)) dataErr++;
        objMem[objWrAddr] = objWrData;
        wrIdx++;
        lastWrCyc = cyc;
      end
      if (done) begin
        doneCnt++;
        doneCyc = cyc;
        if (stall) doneStallErr++;
      end
      prevRd = memRdEn;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d, input logic [7:0] oa);
    regWrEn = 1'b1; regAddr = a; regWrData = d; objAddrIn = oa;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
  endtask

  task automatic testReset();
    check(!stall && !done && !memRdEn && !objWrEn, "R9 reset outputs idle",
          {stall, done, memRdEn, objWrEn}, 0);
  endtask

  task automatic testDecoys();
    clearLog();
    regWrite(16'h4015, 8'h33, 8'h00);
    regWrite(16'h2004, 8'h44, 8'h00);
    regWrite(16'h0014, 8'h55, 8'h00);
    repeat (6) @(negedge clk);
    check(stallCnt == 0, "R1 decoy writes raise no stall", stallCnt, 0);
    check(rdIdx == 0, "R1 decoy writes issue no reads", rdIdx, 0);
  endtask

  task automatic runCopy(input logic [7:0] page, input logic [7:0] start,
                         input bit wantOdd, input bit injectBusy, input string tag);
    int trigCyc;
    int waitCnt;
    bit wasOdd;
    if (cyc[0] != wantOdd) @(negedge clk);
    clearLog();
    expPage = page; expStart = start;
    trigCyc = cyc;
    wasOdd = cyc[0];
    objAddrIn = start;
    regWrite(16'h4014, page, start);
    objAddrIn = start ^ 8'h3C;  // live register moves on; the engine must have sampled it
    check(stall == 1'b1, {"R6 stall rises after trigger ", tag}, stall, 1);
    if (injectBusy) begin
      repeat (40) @(negedge clk);
      regWrite(16'h4014, page ^ 8'h55, 8'h77);
    end
    waitCnt = 0;
    while (doneCnt == 0 && waitCnt < 700) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (3) @(negedge clk);
    check(stallCnt == (wasOdd ? 514 : 513), {"R6 stall length ", tag},
          stallCnt, wasOdd ? 514 : 513);
    check(firstRdCyc - trigCyc == (wasOdd ? 3 : 2), {"R5 first read offset ", tag},
          firstRdCyc - trigCyc, wasOdd ? 3 : 2);
    check(wrIdx == 256 && rdIdx == 256, {"R10 byte counts ", tag}, wrIdx, 256);
    check(srcErr == 0, {"R2 source address sequence ", tag}, srcErr, 0);
    check(dstErr == 0, {"R3 destination sequence ", tag}, dstErr, 0);
    check(objMem[start] == memVal({page, 8'h00}) &&
          objMem[8'(start - 8'd1)] == memVal({page, 8'hFF}),
          {"R3 first and last byte placement ", tag},
          int'(objMem[start]), int'(memVal({page, 8'h00})));
    check(altErr == 0 && dataErr == 0, {"R4 read-write pairing ", tag},
          altErr + dataErr, 0);
    check(doneCnt == 1 && doneCyc == lastWrCyc + 1 && doneStallErr == 0,
          {"R7 done pulse ", tag}, doneCyc, lastWrCyc + 1);
    if (injectBusy)
      check(srcErr == 0 && rdIdx == 256 && doneCnt == 1,
            "R8 busy trigger ignored", srcErr + doneCnt, 1);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 100000) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: cycles=%0d expected below %0d", wdog, 100000);
      finishRun();
    end
  end

  initial begin
    clearLog();
    expPage = '0; expStart = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDecoys();
    runCopy(8'h12, 8'h00, 1'b0, 1'b0, "even start 0");
    runCopy(8'hC0, 8'hF3, 1'b1, 1'b0, "odd wrap F3");
    runCopy(8'h00, 8'h80, 1'b0, 1'b1, "busy retrigger");
    runCopy(8'hFF, 8'h01, 1'b1, 1'b0, "top page");
    testReset();
    finishRun();
  end

endmodule